// File: doc/BRIEF.md
# Dual-Clock FIFO with Mode-Selectable Flags

This block is a first-in first-out buffer whose write side and read side each run on their own clock. The two clocks may be unrelated or may be the same clock. Each side has an enable that qualifies a transfer on the rising edge of that side's clock. By default the buffer stores 1024 words of 36 bits, and both the depth and the width are parameters. Each pointer crosses into the other clock domain as Gray code through a chain of synchronizer flops. Because the copy on the far side is always a little behind, the flags can report the buffer as fuller or emptier than it is, but never the reverse.

A mode input, sampled during master reset, picks one of two read behaviours. In standard mode every word, including the first, needs a read request before it reaches `rd_data`. In that mode `rd_rdy` means "not empty" and `wr_rdy` means "not full". In fall-through mode the oldest word moves to `rd_data` by itself, and `rd_rdy` means that the word shown there is valid. Almost-empty and almost-full thresholds are set during master reset. They come from one of three preset values, or they are loaded later, either from the write data bus in one cycle or bit by bit through a serial input.

A partial reset empties the buffer. It keeps the mode, the loading method and the loaded thresholds.

Top module: `dualclk_fifo`

## Requirements
- R1: After a master or partial reset, and before any write, `rd_rdy`=0, `wr_rdy`=1, `almost_empty`=1 and `almost_full`=0.
- R2: In standard mode (`fwft_sel`=0 at master reset), words leave in write order. `rd_data` changes only at a `rd_clk` edge that samples `rd_en`=1 while `rd_rdy`=1. A word written into an empty buffer does not reach `rd_data` until it is read.
- R3: In fall-through mode (`fwft_sel`=1 at master reset), the oldest word appears on `rd_data` with `rd_rdy`=1 without any read. Each read (`rd_en`=1 while `rd_rdy`=1) moves the next word onto `rd_data`. `rd_rdy` returns to 0 when no word is left.
- R4: `wr_rdy` is 0 once DEPTH words are held in memory. A write while `wr_rdy`=0 is dropped and never appears on the read side.
- R5: In standard mode, a read while `rd_rdy`=0 leaves `rd_data` and the read position unchanged. The next word written is still the next word read.
- R6: `almost_empty`=1 exactly when the stored word count is at or below the empty offset. In fall-through mode the count includes the word shown on `rd_data`.
- R7: `almost_full`=1 exactly when DEPTH minus the words held in memory is at or below the full offset. In fall-through mode, the word shown on `rd_data` is not counted as held in memory.
- R8: During master reset, `cfg_sel`=0, 1 or 2 sets both offsets to PRESET_A, PRESET_B or PRESET_C. `cfg_sel`=3 selects programmable offsets: `ser_sel`=0 for parallel loading, `ser_sel`=1 for serial loading. Programmable offsets start at PRESET_A.
- R9: With parallel loading selected, a `wr_clk` edge with `ofs_ld`=1 loads the empty offset from `wr_data[ADDR_W-1:0]` and the full offset from `wr_data[2*ADDR_W-1:ADDR_W]`.
- R10: With serial loading selected, each `wr_clk` edge with `ser_en`=1 shifts in `ser_din`. 2*ADDR_W bits load both offsets: the empty offset comes first, the full offset second, and each is sent most significant bit first.
- R11: A partial reset (`prst_n`=0) empties the buffer and keeps the mode and both offsets.
- R12: A written word makes `rd_rdy` rise only after its pointer has passed the synchronizer stages on `rd_clk`. `rd_rdy` is still 0 just after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low; configuration is captured while it is low |
| prst_n | input | 1 | Partial reset, active low; flushes data, keeps configuration |
| fwft_sel | input | 1 | Mode select sampled at master reset: 1 = fall-through, 0 = standard |
| cfg_sel | input | 2 | Offset source sampled at master reset (0..2 presets, 3 programmable) |
| ser_sel | input | 1 | With cfg_sel=3 at master reset: 1 = serial loading, 0 = parallel loading |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data; also carries parallel offsets |
| ofs_ld | input | 1 | Parallel offset load strobe |
| ser_en | input | 1 | Serial offset shift enable |
| ser_din | input | 1 | Serial offset data bit |
| wr_rdy | output | 1 | Room available (standard: not full; fall-through: input ready) |
| almost_full | output | 1 | Free space at or below the full offset (write-clock domain) |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Read data |
| rd_rdy | output | 1 | Standard: not empty; fall-through: rd_data holds a valid word |
| almost_empty | output | 1 | Stored count at or below the empty offset (read-clock domain) |

## Verification
A wrong pointer or a corrupted synchronized copy shows up at the ports as a reordered, repeated or missing word once the affected location is read. It also shows as flags that no longer match the number of words written, as soon as the flags have settled, which takes a few clock cycles. The bench therefore steps the occupancy through every value from empty to full under each offset source. At every step it compares `rd_rdy`, `wr_rdy`, `almost_empty` and `almost_full` with values it computes from the count, then drains the buffer and checks the order. An offset loaded with the wrong bit order, or lost across a partial reset, moves a threshold by at least one step, so the sweep at that step reports it.

// File: rtl/dualclk_fifo_pkg.sv
package dualclk_fifo_pkg;

   typedef enum logic [1:0] {
      SEL_PRE_A = 2'd0,
      SEL_PRE_B = 2'd1,
      SEL_PRE_C = 2'd2,
      SEL_PROG  = 2'd3
   } ofs_sel_e;

   typedef enum logic [1:0] {
      LD_PRESET   = 2'd0,
      LD_PARALLEL = 2'd1,
      LD_SERIAL   = 2'd2
   } ofs_method_e;

endpackage

// File: rtl/dualclk_fifo_sync.sv
module dualclk_fifo_sync #(
   parameter int W      = 11,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dualclk_fifo_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dualclk_fifo_ram.sv
module dualclk_fifo_ram #(
   parameter int DATA_W = 36,
   parameter int ADDR_W = 10
) (
   input  logic              wr_clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_clk,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge rd_clk) begin
      if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/dualclk_fifo_wr.sv
module dualclk_fifo_wr
   import dualclk_fifo_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int SYNC_STAGES = 2,
   parameter int PRESET_A    = 8,
   parameter int PRESET_B    = 16,
   parameter int PRESET_C    = 64
) (
   input  logic                wr_clk,
   input  logic                rst_n,
   input  logic                mrst_n,
   input  logic [1:0]          cfg_sel,
   input  logic                ser_sel,
   input  logic                wr_en,
   input  logic [2*ADDR_W-1:0] ofs_data,
   input  logic                ofs_ld,
   input  logic                ser_en,
   input  logic                ser_din,
   input  logic [ADDR_W:0]     rgray_in,
   output logic [ADDR_W:0]     wgray,
   output logic [ADDR_W-1:0]   waddr,
   output logic                wr_go,
   output logic                wr_rdy,
   output logic                almost_full,
   output logic [ADDR_W-1:0]   ae_ofs
);

   localparam int PW = ADDR_W + 1;
   localparam logic [PW-1:0] DEPTH_V = PW'(1 << ADDR_W);

   function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   ofs_method_e       method;
   logic [ADDR_W-1:0] af_ofs;
   logic [PW-1:0]     wbin, wbin_nxt, rq, used, free_cnt;
   logic              full;

   // configuration: captured while master reset is held, then loadable
   always_ff @(posedge wr_clk) begin
      if (!mrst_n) begin
         unique case (ofs_sel_e'(cfg_sel))
            SEL_PRE_A: begin method <= LD_PRESET; ae_ofs <= ADDR_W'(PRESET_A); af_ofs <= ADDR_W'(PRESET_A); end
            SEL_PRE_B: begin method <= LD_PRESET; ae_ofs <= ADDR_W'(PRESET_B); af_ofs <= ADDR_W'(PRESET_B); end
            SEL_PRE_C: begin method <= LD_PRESET; ae_ofs <= ADDR_W'(PRESET_C); af_ofs <= ADDR_W'(PRESET_C); end
            default: begin
               method <= ser_sel ? LD_SERIAL : LD_PARALLEL;
               ae_ofs <= ADDR_W'(PRESET_A);
               af_ofs <= ADDR_W'(PRESET_A);
            end
         endcase
      end else if (method == LD_PARALLEL && ofs_ld) begin
         ae_ofs <= ofs_data[ADDR_W-1:0];
         af_ofs <= ofs_data[2*ADDR_W-1:ADDR_W];
      end else if (method == LD_SERIAL && ser_en) begin
         {ae_ofs, af_ofs} <= {ae_ofs[ADDR_W-2:0], af_ofs, ser_din};
      end
   end

   dualclk_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
      .clk   (wr_clk),
      .rst_n (rst_n),
      .d     (rgray_in),
      .q     (rq)
   );

   assign full     = (wgray == {~rq[PW-1:PW-2], rq[PW-3:0]});
   assign wr_rdy   = !full;
   assign wr_go    = wr_en && !full;
   assign wbin_nxt = wbin + PW'(1);
   assign waddr    = wbin[ADDR_W-1:0];

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_go) begin
         wbin  <= wbin_nxt;
         wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      end
   end

   assign used        = wbin - gray2bin(rq);
   assign free_cnt    = DEPTH_V - used;
   assign almost_full = (free_cnt <= {1'b0, af_ofs});

   assert_no_overflow_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_en && !wr_rdy) |=> $stable(wbin));

   assert_used_bound_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
      used <= DEPTH_V);

   assert_wgray_step_R12: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1);

endmodule

// File: rtl/dualclk_fifo_rd.sv
module dualclk_fifo_rd #(
   parameter int ADDR_W      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              mrst_n,
   input  logic              fwft_sel,
   input  logic              rd_en,
   input  logic [ADDR_W:0]   wgray_in,
   input  logic [ADDR_W-1:0] ae_ofs,
   output logic [ADDR_W:0]   rgray,
   output logic [ADDR_W-1:0] raddr,
   output logic              fetch,
   output logic              rd_rdy,
   output logic              almost_empty
);

   localparam int PW = ADDR_W + 1;

   function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic          fwft_q, or_q, ram_empty;
   logic [PW-1:0] rbin, rbin_nxt, wq, occ;

   // mode is captured while master reset is held; partial reset keeps it
   always_ff @(posedge rd_clk) begin
      if (!mrst_n) fwft_q <= fwft_sel;
   end

   dualclk_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
      .clk   (rd_clk),
      .rst_n (rst_n),
      .d     (wgray_in),
      .q     (wq)
   );

   assign ram_empty = (rgray == wq);
   assign fetch     = fwft_q ? (!ram_empty && (!or_q || rd_en))
                             : (rd_en && !ram_empty);
   assign rbin_nxt  = rbin + PW'(1);
   assign raddr     = rbin[ADDR_W-1:0];

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (fetch) begin
         rbin  <= rbin_nxt;
         rgray <= rbin_nxt ^ (rbin_nxt >> 1);
      end
   end

   // output-register valid flag, used only in fall-through mode
   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)             or_q <= 1'b0;
      else if (!fwft_q)       or_q <= 1'b0;
      else if (fetch)         or_q <= 1'b1;
      else if (rd_en)         or_q <= 1'b0;
   end

   assign rd_rdy       = fwft_q ? or_q : !ram_empty;
   assign occ          = gray2bin(wq) - rbin + {{ADDR_W{1'b0}}, (fwft_q & or_q)};
   assign almost_empty = (occ <= {1'b0, ae_ofs});

   assert_no_underflow_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_en && ram_empty) |=> $stable(rbin));

   assert_or_drop_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $fell(or_q) |-> $past(rd_en));

   assert_rgray_step_R12: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $countones(rgray ^ $past(rgray)) <= 1);

endmodule

// File: rtl/dualclk_fifo.sv
module dualclk_fifo #(
   parameter int DATA_W      = 36,
   parameter int ADDR_W      = 10,
   parameter int SYNC_STAGES = 2,
   parameter int PRESET_A    = 8,
   parameter int PRESET_B    = 16,
   parameter int PRESET_C    = 64
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              fwft_sel,
   input  logic [1:0]        cfg_sel,
   input  logic              ser_sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ofs_ld,
   input  logic              ser_en,
   input  logic              ser_din,
   output logic              wr_rdy,
   output logic              almost_full,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_rdy,
   output logic              almost_empty
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam int PW    = ADDR_W + 1;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("dualclk_fifo: ADDR_W must be at least 2");
   end
   if (DATA_W < 2 * ADDR_W) begin : g_bad_width
      $error("dualclk_fifo: DATA_W must carry both parallel offsets");
   end
   if (PRESET_A >= DEPTH || PRESET_B >= DEPTH || PRESET_C >= DEPTH) begin : g_bad_preset
      $error("dualclk_fifo: preset offsets must be below DEPTH");
   end

   logic              ptr_rst_n;
   logic [PW-1:0]     wgray, rgray;
   logic [ADDR_W-1:0] waddr, raddr, ae_ofs;
   logic              wr_go, fetch;

   assign ptr_rst_n = mrst_n & prst_n;

   dualclk_fifo_wr #(
      .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
      .PRESET_A(PRESET_A), .PRESET_B(PRESET_B), .PRESET_C(PRESET_C)
   ) u_wr (
      .wr_clk      (wr_clk),
      .rst_n       (ptr_rst_n),
      .mrst_n      (mrst_n),
      .cfg_sel     (cfg_sel),
      .ser_sel     (ser_sel),
      .wr_en       (wr_en),
      .ofs_data    (wr_data[2*ADDR_W-1:0]),
      .ofs_ld      (ofs_ld),
      .ser_en      (ser_en),
      .ser_din     (ser_din),
      .rgray_in    (rgray),
      .wgray       (wgray),
      .waddr       (waddr),
      .wr_go       (wr_go),
      .wr_rdy      (wr_rdy),
      .almost_full (almost_full),
      .ae_ofs      (ae_ofs)
   );

   dualclk_fifo_rd #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
      .rd_clk       (rd_clk),
      .rst_n        (ptr_rst_n),
      .mrst_n       (mrst_n),
      .fwft_sel     (fwft_sel),
      .rd_en        (rd_en),
      .wgray_in     (wgray),
      .ae_ofs       (ae_ofs),
      .rgray        (rgray),
      .raddr        (raddr),
      .fetch        (fetch),
      .rd_rdy       (rd_rdy),
      .almost_empty (almost_empty)
   );

   dualclk_fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .wr_clk (wr_clk),
      .we     (wr_go),
      .waddr  (waddr),
      .wdata  (wr_data),
      .rd_clk (rd_clk),
      .re     (fetch),
      .raddr  (raddr),
      .rdata  (rd_data)
   );

endmodule

// File: tb/dualclk_fifo_tb.sv
`timescale 1ns/1ps
module dualclk_fifo_tb;

   localparam int DW    = 16;
   localparam int AW    = 4;
   localparam int DEPTH = 1 << AW;

   logic          wr_clk, rd_clk, mrst_n, prst_n, fwft_sel, ser_sel;
   logic [1:0]    cfg_sel;
   logic          wr_en, ofs_ld, ser_en, ser_din, rd_en;
   logic [DW-1:0] wr_data, rd_data;
   logic          wr_rdy, almost_full, rd_rdy, almost_empty;

   int checks = 0;
   int errors = 0;

   dualclk_fifo #(
      .DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2),
      .PRESET_A(2), .PRESET_B(4), .PRESET_C(6)
   ) u_dut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .fwft_sel(fwft_sel), .cfg_sel(cfg_sel), .ser_sel(ser_sel),
      .wr_en(wr_en), .wr_data(wr_data), .ofs_ld(ofs_ld), .ser_en(ser_en),
      .ser_din(ser_din), .wr_rdy(wr_rdy), .almost_full(almost_full),
      .rd_en(rd_en), .rd_data(rd_data), .rd_rdy(rd_rdy),
      .almost_empty(almost_empty)
   );

   initial wr_clk = 1'b0;
   always #2.5 wr_clk = ~wr_clk;
   initial begin
      rd_clk = 1'b0;
      #1.2;
      forever #2.5 rd_clk = ~rd_clk;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(posedge wr_clk);
      repeat (6) @(posedge rd_clk);
      #1;
   endtask

   task automatic do_mrst(input logic fw, input logic [1:0] cs, input logic ss);
      mrst_n = 1'b0; fwft_sel = fw; cfg_sel = cs; ser_sel = ss;
      repeat (4) @(posedge wr_clk);
      repeat (4) @(posedge rd_clk);
      #1 mrst_n = 1'b1;
      settle();
   endtask

   task automatic do_prst();
      prst_n = 1'b0;
      repeat (3) @(posedge wr_clk);
      repeat (3) @(posedge rd_clk);
      #1 prst_n = 1'b1;
      settle();
   endtask

   task automatic wr1(input logic [DW-1:0] d);
      @(posedge wr_clk); #1;
      wr_en = 1'b1; wr_data = d;
      @(posedge wr_clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd1();
      @(posedge rd_clk); #1 rd_en = 1'b1;
      @(posedge rd_clk); #1 rd_en = 1'b0;
   endtask

   task automatic reset_flags(input string req);
      chk(rd_rdy == 1'b0, req, "rd_rdy after reset", 32'(rd_rdy), 0);
      chk(wr_rdy == 1'b1, req, "wr_rdy after reset", 32'(wr_rdy), 1);
      chk(almost_empty == 1'b1, req, "almost_empty after reset", 32'(almost_empty), 1);
      chk(almost_full == 1'b0, req, "almost_full after reset", 32'(almost_full), 0);
   endtask

   // steps occupancy from 0 to DEPTH, checking all flags, then drains and checks order
   task automatic sweep(input bit fw, input int ae_o, input int af_o,
                        input logic [DW-1:0] base, input string tag);
      for (int n = 0; n <= DEPTH; n++) begin
         int mw;
         settle();
         mw = (fw && n > 0) ? n - 1 : n;
         chk(almost_empty == (n <= ae_o), {"R6 ", tag}, "almost_empty", 32'(almost_empty), 32'(n <= ae_o));
         chk(almost_full == ((DEPTH - mw) <= af_o), {"R7 ", tag}, "almost_full", 32'(almost_full), 32'((DEPTH - mw) <= af_o));
         chk(rd_rdy == (n > 0), {"R2 ", tag}, "rd_rdy", 32'(rd_rdy), 32'(n > 0));
         chk(wr_rdy == (mw < DEPTH), {"R4 ", tag}, "wr_rdy", 32'(wr_rdy), 32'(mw < DEPTH));
         if (n < DEPTH) wr1(base + DW'(n));
      end
      for (int n = 0; n < DEPTH; n++) begin
         if (fw) begin
            chk(rd_data == base + DW'(n), {"R3 ", tag}, "fall-through order", 32'(rd_data), 32'(base + DW'(n)));
            rd1();
         end else begin
            rd1();
            chk(rd_data == base + DW'(n), {"R2 ", tag}, "read order", 32'(rd_data), 32'(base + DW'(n)));
         end
      end
      settle();
      chk(rd_rdy == 1'b0, {"R2 ", tag}, "drained rd_rdy", 32'(rd_rdy), 0);
   endtask

   initial begin : watchdog
      #900000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [DW-1:0] held;
      logic [2*AW-1:0] sbits;
      mrst_n = 1'b0; prst_n = 1'b1; fwft_sel = 1'b0; cfg_sel = 2'd0; ser_sel = 1'b0;
      wr_en = 1'b0; wr_data = '0; ofs_ld = 1'b0; ser_en = 1'b0; ser_din = 1'b0; rd_en = 1'b0;

      // R1 reset state and R8 first preset, standard mode
      do_mrst(1'b0, 2'd0, 1'b0);
      reset_flags("R1");
      sweep(1'b0, 2, 2, 16'h0100, "R8 preset A");

      // R4 write while full is dropped
      for (int i = 0; i < DEPTH; i++) wr1(16'h0200 + DW'(i));
      settle();
      chk(wr_rdy == 1'b0, "R4", "wr_rdy when full", 32'(wr_rdy), 0);
      wr1(16'h02FF);
      for (int i = 0; i < DEPTH; i++) begin
         rd1();
         chk(rd_data == 16'h0200 + DW'(i), "R4", "data after dropped write", 32'(rd_data), 32'(16'h0200 + DW'(i)));
      end
      settle();
      chk(rd_rdy == 1'b0, "R4", "dropped word absent", 32'(rd_rdy), 0);

      // R5 read while empty ignored; R12 sync latency; R2 no show without read
      held = rd_data;
      rd1();
      chk(rd_data === held, "R5", "rd_data held on empty read", 32'(rd_data), 32'(held));
      wr1(16'h0333);
      chk(rd_rdy == 1'b0, "R12", "rd_rdy right after write", 32'(rd_rdy), 0);
      settle();
      chk(rd_rdy == 1'b1, "R12", "rd_rdy after sync", 32'(rd_rdy), 1);
      chk(rd_data === held, "R2", "word not shown before read", 32'(rd_data), 32'(held));
      rd1();
      chk(rd_data == 16'h0333, "R5", "pointer unchanged by empty read", 32'(rd_data), 32'h0333);
      settle();

      // R8 remaining presets
      do_mrst(1'b0, 2'd1, 1'b0);
      sweep(1'b0, 4, 4, 16'h1000, "R8 preset B");
      do_mrst(1'b0, 2'd2, 1'b0);
      sweep(1'b0, 6, 6, 16'h2000, "R8 preset C");

      // R9 parallel loading: empty offset 7, full offset 1
      do_mrst(1'b0, 2'd3, 1'b0);
      @(posedge wr_clk); #1;
      ofs_ld = 1'b1; wr_data = DW'({4'd1, 4'd7});
      @(posedge wr_clk); #1;
      ofs_ld = 1'b0;
      sweep(1'b0, 7, 1, 16'h3000, "R9 parallel");

      // R10 serial loading: empty offset 5 then full offset 3, MSB first
      do_mrst(1'b0, 2'd3, 1'b1);
      sbits = {4'd5, 4'd3};
      for (int i = 2 * AW - 1; i >= 0; i--) begin
         @(posedge wr_clk); #1;
         ser_en = 1'b1; ser_din = sbits[i];
      end
      @(posedge wr_clk); #1;
      ser_en = 1'b0;
      sweep(1'b0, 5, 3, 16'h4000, "R10 serial");

      // R11 partial reset flushes and keeps offsets
      for (int i = 0; i < 6; i++) wr1(16'h5000 + DW'(i));
      do_prst();
      reset_flags("R11");
      sweep(1'b0, 5, 3, 16'h6000, "R11 kept offsets");

      // R3 fall-through mode
      do_mrst(1'b1, 2'd0, 1'b0);
      reset_flags("R1 fwft");
      wr1(16'h0400);
      settle();
      chk(rd_rdy == 1'b1, "R3", "rd_rdy without read", 32'(rd_rdy), 1);
      chk(rd_data == 16'h0400, "R3", "first word falls through", 32'(rd_data), 32'h0400);
      rd1();
      settle();
      chk(rd_rdy == 1'b0, "R3", "rd_rdy after last read", 32'(rd_rdy), 0);
      sweep(1'b1, 2, 2, 16'h7000, "R3 fwft");

      // R11 mode kept across partial reset
      wr1(16'h7700);
      do_prst();
      reset_flags("R11 fwft");
      wr1(16'h0555);
      settle();
      chk(rd_rdy == 1'b1, "R11", "fall-through kept rd_rdy", 32'(rd_rdy), 1);
      chk(rd_data == 16'h0555, "R11", "fall-through kept data", 32'(rd_data), 32'h0555);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule